// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital side of a two-channel 16-bit digital-to-analog converter. Both channels share one byte-wide data bus and three active-low select lines. Each channel has its own active-low chip select and write strobe. Inside each channel, a 16-bit word is assembled in two byte-wide input registers and then moved into a 16-bit output register that would drive the converter. The output word is two's complement: 7FFFh is plus full scale, 0000h is zero, FFFFh is one step below zero and 8000h is minus full scale. The block applies no arithmetic to it.

All pins are sampled by a fast system clock through a two-stage synchronizer. The level-sensitive latch behaviour is then reproduced with registers. An enable that stays asserted keeps reloading its register, and a byte and its transfer that are enabled together reach the output in the same update. When the low-byte and high-byte selects are both low, the channel enters a serial mode. In that mode one bit from bus bit 0 is shifted in at the end of each write strobe, most significant bit first. A global clear zeroes every register of both channels and overrides any load in the same cycle.

Top module: `dacfe_dual`

## Requirements
- R1: A channel is addressed only while its synchronized chip select and write strobe are both low. While either one is high, that channel's output word does not change, except through clear.
- R2: While channel c is addressed and select bit 1 (high-byte enable, active low) is low, outside serial mode, the bus byte is loaded into the channel's high-byte register (word bits 15:8).
- R3: While channel c is addressed and select bit 0 (low-byte enable, active low) is low, outside serial mode, the bus byte is loaded into the channel's low-byte register (word bits 7:0).
- R4: While a channel is addressed and select bit 2 (transfer enable, active low) is low, the output word of channel c (`dac_words[16*c +: 16]`) takes {high register, low register}. While select bit 2 is high, the output word holds.
- R5: A byte load and a transfer that are enabled in the same sample act as one transparent path. The bus byte appears in the output word at the same update.
- R6: When select bits 0 and 1 are both low (serial mode), the byte loads are suppressed. Each write strobe that rises after an addressed serial sample shifts {high, low} left by one and inserts bus bit 0, so the first bit shifted in ends up as the MSB. The other bus bits are ignored.
- R7: Clear (pin active low) zeroes both input registers and the output word of both channels. It takes priority over every load, shift and transfer in the same cycle.
- R8: When both channels are addressed with transfer enabled, both output words update from the same bus sample.
- R9: A change at the pins reaches the output word at the third rising clock edge after it is applied: two synchronizer stages plus the register.
- R10: After reset, both output words are 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_n_pin | input | 1 | Global clear, active low |
| bus_pin | input | BYTE_W | Shared data bus; bit 0 carries serial data |
| sel_n_pin | input | 3 | Active-low selects: bit 0 low byte, bit 1 high byte, bit 2 transfer |
| cs_n_pin | input | NCH | Per-channel chip select, active low (bit 0 = channel A) |
| wr_n_pin | input | NCH | Per-channel write strobe, active low |
| dac_words | output | NCH*2*BYTE_W | Output words; channel c at bits [16*c +: 16] |

## Verification
Clear and a byte load with its transfer can fall in the same cycle. The bench provokes this by asserting clear on the same edge on which it opens a flow-through write on channel A. It holds both for several cycles and releases them together. The output must read zero throughout. A later bare transfer must also read zero, which shows that the input registers lost the loaded byte as well. A behavioural model that runs every cycle judges the collision, and a bound property checks the zero word directly.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   // Select bit positions on the shared select lines (all active low)
   localparam int SEL_LO   = 0;
   localparam int SEL_HI   = 1;
   localparam int SEL_XFER = 2;
   localparam int SEL_W    = 3;

   typedef enum logic [1:0] {
      MODE_IDLE     = 2'd0,
      MODE_PARALLEL = 2'd1,
      MODE_SERIAL   = 2'd2
   } chan_mode_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel
   import dacfe_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [SEL_W-1:0]  sel_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic [BYTE_W-1:0] bus,
   output logic [WORD_W-1:0] word_q
);
   logic [BYTE_W-1:0] hi_q, lo_q, hi_n, lo_n;
   logic [WORD_W-1:0] shifted;
   logic              addressed, ser_sel, ser_arm_q, shift_now;
   chan_mode_e        mode;

   assign addressed = !cs_n && !wr_n;
   assign ser_sel   = !sel_n[SEL_LO] && !sel_n[SEL_HI];
   assign shift_now = ser_arm_q && wr_n;
   assign shifted   = {hi_q[BYTE_W-2:0], lo_q, bus[0]};

   always_comb begin
      if (!addressed)   mode = MODE_IDLE;
      else if (ser_sel) mode = MODE_SERIAL;
      else              mode = MODE_PARALLEL;
   end

   always_comb begin
      hi_n = hi_q;
      lo_n = lo_q;
      if (mode == MODE_PARALLEL) begin
         if (!sel_n[SEL_HI]) hi_n = bus;
         if (!sel_n[SEL_LO]) lo_n = bus;
      end
      if (shift_now) begin
         hi_n = shifted[WORD_W-1:BYTE_W];
         lo_n = shifted[BYTE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q      <= '0;
         lo_q      <= '0;
         word_q    <= '0;
         ser_arm_q <= 1'b0;
      end else begin
         ser_arm_q <= (mode == MODE_SERIAL);
         if (clr) begin
            hi_q   <= '0;
            lo_q   <= '0;
            word_q <= '0;
         end else begin
            hi_q <= hi_n;
            lo_q <= lo_n;
            if (addressed && !sel_n[SEL_XFER]) word_q <= {hi_n, lo_n};
         end
      end
   end
endmodule

// File: rtl/dacfe_dual.sv
module dacfe_dual
   import dacfe_pkg::*;
#(
   parameter int NCH = 2,
   parameter int BYTE_W = 8,
   parameter int SYNC_STAGES = 2,
   localparam int WORD_W = 2 * BYTE_W,
   localparam int PIN_W = 1 + BYTE_W + SEL_W + 2 * NCH
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_n_pin,
   input  logic [BYTE_W-1:0]     bus_pin,
   input  logic [SEL_W-1:0]      sel_n_pin,
   input  logic [NCH-1:0]        cs_n_pin,
   input  logic [NCH-1:0]        wr_n_pin,
   output logic [NCH*WORD_W-1:0] dac_words
);
   generate
      if (NCH < 1) begin : g_bad_nch
         $error("dacfe_dual: NCH must be at least 1");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("dacfe_dual: BYTE_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dacfe_dual: SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, {BYTE_W{1'b0}}, {SEL_W{1'b1}}, {2*NCH{1'b1}}};

   logic [PIN_W-1:0]  pins_raw, pins_s;
   logic              clr_n_s, clr_s;
   logic [BYTE_W-1:0] bus_s;
   logic [SEL_W-1:0]  sel_s;
   logic [NCH-1:0]    cs_s, wr_s;

   assign pins_raw = {clr_n_pin, bus_pin, sel_n_pin, cs_n_pin, wr_n_pin};

   dacfe_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
   );

   assign {clr_n_s, bus_s, sel_s, cs_s, wr_s} = pins_s;
   assign clr_s = !clr_n_s;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dacfe_channel #(.BYTE_W(BYTE_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .clr(clr_s), .sel_n(sel_s),
         .cs_n(cs_s[c]), .wr_n(wr_s[c]), .bus(bus_s),
         .word_q(dac_words[c*WORD_W +: WORD_W])
      );
   end
endmodule

// File: rtl/dacfe_dual_chk.sv
module dacfe_dual_chk #(
   parameter int NCH = 2,
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  clr_s,
   input logic [BYTE_W-1:0]     bus_s,
   input logic [2:0]            sel_s,
   input logic [NCH-1:0]        cs_s,
   input logic [NCH-1:0]        wr_s,
   input logic [NCH*WORD_W-1:0] dac_words
);
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_s |=> (dac_words == '0)); // R7

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      AST_UNADDRESSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         ((cs_s[c] || wr_s[c]) && !clr_s) |=> $stable(dac_words[c*WORD_W +: WORD_W])); // R1

      AST_NO_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_s[2] && !clr_s) |=> $stable(dac_words[c*WORD_W +: WORD_W])); // R4

      AST_FLOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_s[c] && !wr_s[c] && !sel_s[2] && !sel_s[1] && sel_s[0] && !clr_s)
         |=> (dac_words[c*WORD_W+BYTE_W +: BYTE_W] == $past(bus_s))); // R5

      if (c > 0) begin : g_pair
         AST_SHARED_XFER: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_s[0] && !wr_s[0] && !cs_s[c] && !wr_s[c] && !sel_s[2] && !sel_s[1]
             && sel_s[0] && !clr_s)
            |=> (dac_words[c*WORD_W+BYTE_W +: BYTE_W] == dac_words[BYTE_W +: BYTE_W])); // R8
      end
   end
endmodule

bind dacfe_dual dacfe_dual_chk #(.NCH(NCH), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .bus_s(bus_s), .sel_s(sel_s),
   .cs_s(cs_s), .wr_s(wr_s), .dac_words(dac_words)
);

// File: tb/dacfe_dual_test.sv
`timescale 1ns/1ps
module dacfe_dual_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_n_pin = 1'b1;
   logic [7:0]  bus_pin = 8'h00;
   logic [2:0]  sel_n_pin = 3'b111;
   logic [1:0]  cs_n_pin = 2'b11;
   logic [1:0]  wr_n_pin = 2'b11;
   logic [31:0] dac_words;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dacfe_dual uut (
      .clk(clk), .rst_n(rst_n), .clr_n_pin(clr_n_pin), .bus_pin(bus_pin),
      .sel_n_pin(sel_n_pin), .cs_n_pin(cs_n_pin), .wr_n_pin(wr_n_pin),
      .dac_words(dac_words)
   );

   // Reference model: pin samples pass a queue of depth three, i.e. the
   // value acting at an edge is the one applied two edges earlier.
   // Sample packing: {clr_n, bus[7:0], sel_n[2:0], cs_n[1:0], wr_n[1:0]}
   logic [15:0] hist[$];
   logic [7:0]  m_hi[2], m_lo[2];
   logic [15:0] m_dac[2];
   localparam logic [15:0] IDLE_SMP = {1'b1, 8'h00, 3'b111, 2'b11, 2'b11};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = {IDLE_SMP, IDLE_SMP, IDLE_SMP};
         for (int c = 0; c < 2; c++) begin
            m_hi[c] = 0; m_lo[c] = 0; m_dac[c] = 0;
         end
      end else begin
         logic [15:0] cur, prv;
         cur = hist[1];
         prv = hist[0];
         for (int c = 0; c < 2; c++) begin
            bit cl, adr, ser, arm, shf;
            logic [7:0] nh, nl, b;
            logic [15:0] w;
            b   = cur[14:7];
            cl  = !cur[15];
            adr = !cur[2+c] && !cur[c];
            ser = !cur[4] && !cur[5];
            arm = !prv[2+c] && !prv[c] && !prv[4] && !prv[5];
            shf = arm && cur[c];
            if (cl) begin
               m_hi[c] = 0; m_lo[c] = 0; m_dac[c] = 0;
            end else begin
               nh = m_hi[c]; nl = m_lo[c];
               if (adr && !ser) begin
                  if (!cur[5]) nh = b;
                  if (!cur[4]) nl = b;
               end
               if (shf) begin
                  w = {m_hi[c], m_lo[c]} << 1;
                  w[0] = b[0];
                  nh = w[15:8]; nl = w[7:0];
               end
               m_hi[c] = nh; m_lo[c] = nl;
               if (adr && !cur[6]) m_dac[c] = {nh, nl};
            end
         end
         void'(hist.pop_front());
         hist.push_back({clr_n_pin, bus_pin, sel_n_pin, cs_n_pin, wr_n_pin});
      end
   end

   // Every-cycle comparison (R9 timing)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (dac_words !== {m_dac[1], m_dac[0]}) begin
            errors++;
            $display("FAIL R9 cycle compare got %h expected %h", dac_words, {m_dac[1], m_dac[0]});
         end
      end
   end

   task automatic chk(input string tag, input int ch, input logic [15:0] exp);
      logic [15:0] got;
      got = dac_words[ch*16 +: 16];
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s ch%0d got %h expected %h", tag, ch, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wpulse(input logic [1:0] chs, input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      cs_n_pin = ~chs; sel_n_pin = sel; bus_pin = d;
      @(negedge clk);
      wr_n_pin = ~chs;
      repeat (2) @(negedge clk);
      wr_n_pin = 2'b11;
      @(negedge clk);
      cs_n_pin = 2'b11;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(4);
      chk("R10", 0, 16'h0000);
      chk("R10", 1, 16'h0000);

      // R2/R3: bytes land in input registers only; output holds (R4)
      wpulse(2'b01, 3'b101, 8'h12); idle(4);
      chk("R4", 0, 16'h0000);
      wpulse(2'b01, 3'b110, 8'h34); idle(4);
      chk("R4", 0, 16'h0000);
      wpulse(2'b01, 3'b011, 8'hEE); idle(4);
      chk("R2", 0, 16'h1234);
      chk("R3", 0, 16'h1234);
      chk("R1", 1, 16'h0000);

      // R1: strobe without select, then select without strobe
      @(negedge clk); cs_n_pin = 2'b11; wr_n_pin = 2'b00; sel_n_pin = 3'b001; bus_pin = 8'hFF;
      idle(4);
      chk("R1", 0, 16'h1234);
      chk("R1", 1, 16'h0000);
      @(negedge clk); cs_n_pin = 2'b00; wr_n_pin = 2'b11;
      idle(4);
      chk("R1", 0, 16'h1234);
      chk("R1", 1, 16'h0000);
      @(negedge clk); cs_n_pin = 2'b11;
      idle(2);

      // R5: flow-through of high byte, then low byte, on channel B
      wpulse(2'b10, 3'b001, 8'hAB); idle(4);
      chk("R5", 1, 16'hAB00);
      wpulse(2'b10, 3'b010, 8'hCD); idle(4);
      chk("R5", 1, 16'hABCD);

      // R8: both channels take the same flow-through high byte
      wpulse(2'b11, 3'b001, 8'h80); idle(4);
      chk("R8", 0, 16'h8034);
      chk("R8", 1, 16'h80CD);

      // R6: serial 7FFF into channel A, noise on upper bus bits
      for (int i = 15; i >= 0; i--) begin
         logic [15:0] v;
         v = 16'h7FFF;
         wpulse(2'b01, 3'b100, {7'b1010101, v[i]});
      end
      idle(4);
      chk("R6", 0, 16'h8034);
      wpulse(2'b01, 3'b011, 8'h00); idle(4);
      chk("R6", 0, 16'h7FFF);
      chk("R6", 1, 16'h80CD);

      // R7: clear collides with a flow-through write on channel A
      @(negedge clk);
      cs_n_pin = 2'b10; wr_n_pin = 2'b10; sel_n_pin = 3'b001; bus_pin = 8'h44; clr_n_pin = 1'b0;
      idle(4);
      chk("R7", 0, 16'h0000);
      chk("R7", 1, 16'h0000);
      @(negedge clk);
      cs_n_pin = 2'b11; wr_n_pin = 2'b11; clr_n_pin = 1'b1;
      idle(3);
      wpulse(2'b11, 3'b011, 8'h00); idle(4);
      chk("R7", 0, 16'h0000);
      chk("R7", 1, 16'h0000);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule